// File: doc/BRIEF.md
# Single-Wire Memory Command Engine

This block is the byte-level command layer of a slave memory that sits on a single shared data wire. The bit-level layer below it hands over each received byte with a one-cycle strobe. It also signals each time the master opens a read slot and wants a byte, and it flags every bus reset. The engine decodes the memory command, runs the address pointer and returns transmit bytes. It models the nonvolatile programming step as a busy interval of fixed length.

The block holds two storage pages. The data page has 32 bytes of array behind 32 bytes of scratchpad. The register page has 8 bytes of one-time-programmable register behind 8 bytes of scratchpad. A status byte reports whether the register has been locked. Copies from a scratchpad into its backing store need a key byte, and an unknown command or a wrong key parks the engine until the next bus reset. Once the register is locked, register reads come from the locked copy and register writes are thrown away. Both page depths must be powers of two. The data page must not be smaller than the register page.

Top module: `swmem_cmd_engine`

## Requirements
- R1: After `rst`, `busy_o` and `tx_valid_o` are low, both pages read as 00h, and the status byte reads FFh.
- R2: Command 0Fh takes one address byte, masked to its low 5 bits. Each following byte is written into the data scratchpad, and the pointer steps after every byte, wrapping from 1Fh to 00h.
- R3: Command AAh takes one address byte, masked to 5 bits, and then reads the data scratchpad with the same increment and wrap. In a read phase, a `tx_req_i` pulse gives `tx_valid_o` with the byte exactly one cycle later. Outside a read phase, `tx_req_i` gives no `tx_valid_o`.
- R4: Command 55h followed by key A5h copies the whole data scratchpad into the data array. `busy_o` rises on the cycle after the key and stays high for exactly `PROG_CYCLES` cycles.
- R5: Command F0h first loads the whole data array into the data scratchpad. An address byte may follow, and the scratchpad is then read as in R3. A bus reset straight after F0h leaves only the load done.
- R6: Command 99h takes an address byte, masked to its low 3 bits, and writes the register scratchpad, wrapping from 07h to 00h. While the register is locked, the written bytes are discarded.
- R7: Command C3h takes an address byte, masked to 3 bits, and reads with wrap at 07h. It reads from the register scratchpad while unlocked and from the locked register afterwards.
- R8: Command 5Ah followed by key A5h copies the register scratchpad into the register, sets the lock and starts the R4 busy interval. A bus reset in place of the key cancels the command. Once locked, a further 5Ah/A5h changes nothing and raises no busy.
- R9: Command 66h followed by key 00h returns the status byte on every read request. The status byte is FFh while unlocked and FCh once locked.
- R10: An unknown command code, a copy key other than A5h, or a status key other than 00h aborts the command with no state change. All bytes and read requests are then ignored until a bus reset.
- R11: A command byte that arrives while `busy_o` is high is ignored, along with all bytes after it, until a bus reset. A bus reset does not shorten the busy interval.
- R12: `bus_rst_i` returns the engine to waiting for a command from any state, and `tx_valid_o` is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | Bus reset seen on the wire (one-cycle pulse) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Master opened a read slot and wants a byte |
| tx_valid_o | output | 1 | Transmit byte valid (registered) |
| tx_byte_o | output | 8 | Transmit byte (registered) |
| busy_o | output | 1 | Nonvolatile copy in progress |

## Verification
The bench builds the engine with the default 32-byte and 8-byte pages and a 20-cycle programming interval. This short interval makes it possible to measure every busy window exactly, cycle by cycle, and to inject commands in the middle of one. With the real page sizes, each sweep runs past the end of its page. The sweeps start at addresses whose upper bits must be masked away, so both wrap points and both masks are covered with every byte compared against an arithmetic pattern.

// File: rtl/swmem_pkg.sv
package swmem_pkg;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_ADDR_WD,
    ST_ADDR_RD,
    ST_ADDR_WR,
    ST_ADDR_RR,
    ST_WR_DATA,
    ST_RD_DATA,
    ST_WR_REG,
    ST_RD_REG,
    ST_KEY_COPY,
    ST_KEY_LOCK,
    ST_KEY_STAT,
    ST_RD_STAT,
    ST_HALT
  } eng_state_t;

  localparam logic [7:0] OP_WR_DSP   = 8'h0F;
  localparam logic [7:0] OP_RD_DSP   = 8'hAA;
  localparam logic [7:0] OP_CP_DSP   = 8'h55;
  localparam logic [7:0] OP_LOAD_RD  = 8'hF0;
  localparam logic [7:0] OP_WR_RSP   = 8'h99;
  localparam logic [7:0] OP_RD_REG   = 8'hC3;
  localparam logic [7:0] OP_LOCK     = 8'h5A;
  localparam logic [7:0] OP_STATUS   = 8'h66;

  localparam logic [7:0] KEY_COPY    = 8'hA5;
  localparam logic [7:0] KEY_STATUS  = 8'h00;

  localparam logic [7:0] STAT_OPEN   = 8'hFF;
  localparam logic [7:0] STAT_LOCKED = 8'hFC;

endpackage

// File: rtl/swmem_page.sv
module swmem_page #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sp_we,
  input  logic [AW-1:0] sp_addr,
  input  logic [7:0]    sp_wdata,
  input  logic          load,
  input  logic          commit,
  input  logic          rd_main,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] sp_q   [DEPTH];
  logic [7:0] main_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        sp_q[i]   <= 8'h00;
        main_q[i] <= 8'h00;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (load)
          sp_q[i] <= main_q[i];
        else if (sp_we && sp_addr == AW'(i))
          sp_q[i] <= sp_wdata;
        if (commit)
          main_q[i] <= sp_q[i];
      end
    end
  end

  assign rd_data = rd_main ? main_q[rd_addr] : sp_q[rd_addr];

endmodule

// File: rtl/swmem_busy_timer.sv
module swmem_busy_timer #(
  parameter int CYCLES = 2_000_000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/swmem_cmd_engine.sv
module swmem_cmd_engine
  import swmem_pkg::*;
#(
  parameter int DATA_BYTES  = 32,
  parameter int REG_BYTES   = 8,
  parameter int PROG_CYCLES = 2_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_rst_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       tx_req_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       busy_o
);

  localparam int DAW = $clog2(DATA_BYTES);
  localparam int RAW = $clog2(REG_BYTES);

  eng_state_t     state_q;
  logic [DAW-1:0] ptr_q;
  logic           lock_q;
  logic [7:0]     d_rd, r_rd;
  logic           rx_ok;
  logic           d_we, d_load, d_commit, r_we, r_commit;

  assign rx_ok    = rx_valid_i && !bus_rst_i;
  assign d_we     = rx_ok && state_q == ST_WR_DATA;
  assign d_load   = rx_ok && state_q == ST_CMD && !busy_o && rx_byte_i == OP_LOAD_RD;
  assign d_commit = rx_ok && state_q == ST_KEY_COPY && rx_byte_i == KEY_COPY;
  assign r_we     = rx_ok && state_q == ST_WR_REG && !lock_q;
  assign r_commit = rx_ok && state_q == ST_KEY_LOCK && rx_byte_i == KEY_COPY && !lock_q;

  swmem_page #(.DEPTH(DATA_BYTES)) data_pg_i (
    .clk(clk), .rst(rst),
    .sp_we(d_we), .sp_addr(ptr_q), .sp_wdata(rx_byte_i),
    .load(d_load), .commit(d_commit),
    .rd_main(1'b0), .rd_addr(ptr_q), .rd_data(d_rd)
  );

  swmem_page #(.DEPTH(REG_BYTES)) reg_pg_i (
    .clk(clk), .rst(rst),
    .sp_we(r_we), .sp_addr(ptr_q[RAW-1:0]), .sp_wdata(rx_byte_i),
    .load(1'b0), .commit(r_commit),
    .rd_main(lock_q), .rd_addr(ptr_q[RAW-1:0]), .rd_data(r_rd)
  );

  swmem_busy_timer #(.CYCLES(PROG_CYCLES)) timer_i (
    .clk(clk), .rst(rst),
    .start(d_commit || r_commit),
    .busy_o(busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else if (r_commit) lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CMD;
      ptr_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_byte_o  <= 8'h00;
    end else begin
      tx_valid_o <= 1'b0;
      if (bus_rst_i) begin
        state_q <= ST_CMD;
      end else begin
        if (tx_req_i) begin
          case (state_q)
            ST_RD_DATA: begin
              tx_byte_o  <= d_rd;
              tx_valid_o <= 1'b1;
              ptr_q      <= ptr_q + 1'b1;
            end
            ST_RD_REG: begin
              tx_byte_o  <= r_rd;
              tx_valid_o <= 1'b1;
              ptr_q      <= DAW'(ptr_q[RAW-1:0] + RAW'(1));
            end
            ST_RD_STAT: begin
              tx_byte_o  <= lock_q ? STAT_LOCKED : STAT_OPEN;
              tx_valid_o <= 1'b1;
            end
            default: ;
          endcase
        end
        if (rx_valid_i) begin
          case (state_q)
            ST_CMD: begin
              if (busy_o) state_q <= ST_HALT;
              else begin
                case (rx_byte_i)
                  OP_WR_DSP:  state_q <= ST_ADDR_WD;
                  OP_RD_DSP:  state_q <= ST_ADDR_RD;
                  OP_LOAD_RD: state_q <= ST_ADDR_RD;
                  OP_CP_DSP:  state_q <= ST_KEY_COPY;
                  OP_WR_RSP:  state_q <= ST_ADDR_WR;
                  OP_RD_REG:  state_q <= ST_ADDR_RR;
                  OP_LOCK:    state_q <= ST_KEY_LOCK;
                  OP_STATUS:  state_q <= ST_KEY_STAT;
                  default:    state_q <= ST_HALT;
                endcase
              end
            end
            ST_ADDR_WD: begin
              ptr_q   <= rx_byte_i[DAW-1:0];
              state_q <= ST_WR_DATA;
            end
            ST_ADDR_RD: begin
              ptr_q   <= rx_byte_i[DAW-1:0];
              state_q <= ST_RD_DATA;
            end
            ST_ADDR_WR: begin
              ptr_q   <= DAW'(rx_byte_i[RAW-1:0]);
              state_q <= ST_WR_REG;
            end
            ST_ADDR_RR: begin
              ptr_q   <= DAW'(rx_byte_i[RAW-1:0]);
              state_q <= ST_RD_REG;
            end
            ST_WR_DATA: ptr_q <= ptr_q + 1'b1;
            ST_WR_REG:  ptr_q <= DAW'(ptr_q[RAW-1:0] + RAW'(1));
            ST_KEY_COPY, ST_KEY_LOCK: state_q <= ST_HALT;
            ST_KEY_STAT: state_q <= (rx_byte_i == KEY_STATUS) ? ST_RD_STAT : ST_HALT;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/swmem_cmd_engine_chk.sv
module swmem_cmd_engine_chk #(
  parameter int PROG_CYCLES = 2_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_rst_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_byte_i,
  input logic       tx_req_i,
  input logic       tx_valid_o,
  input logic       busy_o,
  input logic       lock_q
);

  logic [31:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= '0;
  end

  assert_tx_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> $past(tx_req_i));

  assert_busy_after_key_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(rx_valid_i) && $past(rx_byte_i) == 8'hA5));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> run_cnt == PROG_CYCLES);

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  assert_bus_rst_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> !tx_valid_o);

endmodule

bind swmem_cmd_engine swmem_cmd_engine_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i), .rx_valid_i(rx_valid_i),
  .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i), .tx_valid_o(tx_valid_o),
  .busy_o(busy_o), .lock_q(lock_q)
);

// File: tb/swmem_cmd_engine_tb_top.sv
module swmem_cmd_engine_tb_top;

  localparam int PROG = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       tx_req_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_byte_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] sp_m  [32];
  logic [7:0] arr_m [32];
  logic [7:0] rsp_m [8];
  logic [7:0] reg_m [8];

  always #2.5 clk = ~clk;

  swmem_cmd_engine #(.DATA_BYTES(32), .REG_BYTES(8), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst(rst), .bus_rst_i(bus_rst_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i), .tx_valid_o(tx_valid_o),
    .tx_byte_o(tx_byte_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 1'b0;
  endtask

  task automatic bus_reset();
    @(negedge clk); bus_rst_i = 1'b1;
    @(negedge clk); bus_rst_i = 1'b0;
  endtask

  task automatic fetch(output logic v, output logic [7:0] b);
    @(negedge clk); tx_req_i = 1'b1;
    @(negedge clk); tx_req_i = 1'b0;
    v = tx_valid_o; b = tx_byte_o;
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string req);
    logic v; logic [7:0] b;
    fetch(v, b);
    check(v === 1'b1 && b === exp, req, {v, b}, {1'b1, exp});
  endtask

  task automatic expect_none(input string req);
    logic v; logic [7:0] b;
    fetch(v, b);
    check(v === 1'b0, req, v, 0);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy_o; n++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < 32; i++) begin sp_m[i] = 0; arr_m[i] = 0; end
    for (int i = 0; i < 8; i++) begin rsp_m[i] = 0; reg_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(busy_o === 1'b0, "R1 busy", busy_o, 0);
    check(tx_valid_o === 1'b0, "R1 tx_valid", tx_valid_o, 0);
    send(8'hAA); send(8'h00);
    for (int i = 0; i < 32; i++) expect_byte(8'h00, "R1 data scratchpad");
    bus_reset(); send(8'h66); send(8'h00);
    expect_byte(8'hFF, "R1 R9 status unlocked");
    expect_byte(8'hFF, "R9 status repeat");

    // R2 write sweep, masked start 3Dh -> 1Dh, 40 bytes across the wrap
    bus_reset(); send(8'h0F); send(8'h3D);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p;
      p = 8'((i * 37 + 5) & 255);
      send(p);
      sp_m[(29 + i) % 32] = p;
    end
    bus_reset(); send(8'hAA); send(8'hE0);
    for (int i = 0; i < 34; i++) expect_byte(sp_m[i % 32], "R2 R3 scratchpad read wrap");

    // R3 request outside a read phase
    bus_reset(); expect_none("R3 request in command wait");
    send(8'h0F); send(8'h00); expect_none("R3 request in write phase");

    // R4 copy with exact busy length
    bus_reset(); send(8'h55); send(8'hA5);
    for (int i = 0; i < 32; i++) arr_m[i] = sp_m[i];
    cnt = 0;
    if (busy_o) cnt = 1;
    for (int n = 0; n < 200 && busy_o; n++) begin
      @(negedge clk);
      if (busy_o) cnt++;
    end
    check(cnt == PROG, "R4 busy length", cnt, PROG);

    // R11 commands during busy ignored; bus reset does not end busy
    bus_reset(); send(8'h55); send(8'hA5);
    bus_reset();
    check(busy_o === 1'b1, "R11 busy survives bus reset", busy_o, 1);
    send(8'h0F); send(8'h00); send(8'hAB); send(8'hCD);
    wait_idle();
    bus_reset(); send(8'hAA); send(8'h00);
    expect_byte(sp_m[0], "R11 write during busy ignored");
    expect_byte(sp_m[1], "R11 write during busy ignored");

    // R5 load array into scratchpad
    bus_reset(); send(8'h0F); send(8'h00);
    for (int i = 0; i < 32; i++) begin
      sp_m[i] = 8'((i * 11 + 200) & 255);
      send(sp_m[i]);
    end
    bus_reset(); send(8'hF0); bus_reset();
    for (int i = 0; i < 32; i++) sp_m[i] = arr_m[i];
    send(8'hAA); send(8'h00);
    for (int i = 0; i < 32; i++) expect_byte(sp_m[i], "R5 load without read");
    bus_reset(); send(8'hF0); send(8'h25);
    for (int i = 0; i < 33; i++) expect_byte(arr_m[(5 + i) % 32], "R5 load and read");

    // R10 wrong keys and unknown command
    bus_reset(); send(8'h0F); send(8'h00); send(8'h77);
    sp_m[0] = 8'h77;
    bus_reset(); send(8'h55); send(8'h5A);
    check(busy_o === 1'b0, "R10 wrong copy key no busy", busy_o, 0);
    send(8'hAA); send(8'h00); expect_none("R10 bytes ignored after abort");
    bus_reset(); send(8'h66); send(8'h01); expect_none("R10 wrong status key");
    bus_reset(); send(8'h12); send(8'h00); expect_none("R10 unknown command");
    bus_reset(); send(8'hF0); send(8'h00);
    for (int i = 0; i < 32; i++) expect_byte(arr_m[i], "R10 array unchanged by aborted copy");
    for (int i = 0; i < 32; i++) sp_m[i] = arr_m[i];

    // R6 R7 register scratchpad, masked FEh -> 6, read from 0Bh -> 3
    bus_reset(); send(8'h99); send(8'hFE);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] p;
      p = 8'((i * 29 + 1) & 255);
      send(p);
      rsp_m[(6 + i) % 8] = p;
    end
    bus_reset(); send(8'hC3); send(8'h0B);
    for (int i = 0; i < 10; i++) expect_byte(rsp_m[(3 + i) % 8], "R6 R7 register scratchpad wrap");

    // R8 cancel, lock, second lock
    bus_reset(); send(8'h5A); bus_reset();
    check(busy_o === 1'b0, "R8 cancel no busy", busy_o, 0);
    send(8'h66); send(8'h00); expect_byte(8'hFF, "R8 cancel keeps unlocked");
    bus_reset(); send(8'h5A); send(8'hA5);
    check(busy_o === 1'b1, "R8 lock starts busy", busy_o, 1);
    for (int i = 0; i < 8; i++) reg_m[i] = rsp_m[i];
    wait_idle();
    bus_reset(); send(8'h66); send(8'h00); expect_byte(8'hFC, "R9 status locked");
    bus_reset(); send(8'h99); send(8'h00);
    for (int i = 0; i < 8; i++) send(8'h5C);
    bus_reset(); send(8'hC3); send(8'h00);
    for (int i = 0; i < 9; i++) expect_byte(reg_m[i % 8], "R6 R7 locked register read");
    bus_reset(); send(8'h5A); send(8'hA5);
    check(busy_o === 1'b0, "R8 second lock no busy", busy_o, 0);
    bus_reset(); send(8'hC3); send(8'h04);
    for (int i = 0; i < 8; i++) expect_byte(reg_m[(4 + i) % 8], "R8 second lock no change");

    // R12 bus reset mid-read
    bus_reset(); send(8'hAA); send(8'h00);
    expect_byte(sp_m[0], "R12 read before reset");
    bus_reset(); expect_none("R12 no read after bus reset");
    send(8'hAA); send(8'h01); expect_byte(sp_m[1], "R12 new command accepted");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule